// File: doc/BRIEF.md
# Fractional Baud-Rate Tick Generator

This block turns the system clock into the oversampling enable pulse that a UART's transmitter and receiver advance on. The divide ratio is a 16-bit integer plus a 6-bit fraction counted in sixty-fourths. A fraction accumulator lets consecutive tick periods alternate between N and N+1 clocks, so the average period matches the programmed ratio. A second output marks each baud period, which is one pulse for every 16 oversampling ticks, or one for every 8 when the fast-oversampling input is high.

Divisor writes go first into staging registers and have no effect until a line-control write strobe commits them. The committed value is armed, and it is loaded only at a character boundary: the first clock edge at which neither the transmit engine nor the receive engine reports a character in progress. The commit path is a two-state machine. In CM_SYNCED nothing is pending. A line-control write takes it to CM_ARMED, and a further line-control write in CM_ARMED re-captures the staged values and stays in CM_ARMED. When both engines are idle and no line-control write is present, CM_ARMED loads the divisor and returns to CM_SYNCED.

The tick timer is a three-state machine. TG_OFF holds everything cleared while the enable is low. TG_RUN counts the integer part of the period. TG_PAD is the single extra clock of a stretched period. Its transitions are: OFF to RUN on enable; RUN to PAD at the end of the count when the accumulator carries; PAD back to RUN; any state to OFF when the enable drops. A divisor load restarts the timer in RUN, or in OFF if the enable is low.

Top module: `baud_rate_gen`

## Requirements
- R1: While reset is asserted, `os_tick` and `baud_tick` are 0. After reset the active divisor is integer 0 and fraction 0, so with `enable` high `os_tick` is high on every clock.
- R2: With an active integer divisor N of at least 1 and a fraction of 0, rising `os_tick` pulses are exactly N clocks apart. When N is 2 or more, each pulse lasts one clock.
- R3: With integer N of at least 1 and fraction F, the accumulator starts at 0 after a divisor load or after `enable` rises. For each period, S = acc + F. The period lasts N+1 clocks if S ≥ 64 and N clocks otherwise, and acc then becomes S mod 64.
- R4: When the active integer divisor is 0, the divide ratio is 1 and the fraction has no effect. `os_tick` is high on every clock while enabled.
- R5: A write to `div_int_wr` or `div_frac_wr` on its own does not change the tick period.
- R6: A pulse on `lcr_wr` commits the currently staged integer and fraction. The active divisor changes only after such a commit.
- R7: A committed divisor is not loaded while `tx_busy` or `rx_busy` is high. It is loaded at the first clock edge at which both are low, which restarts the period count.
- R8: `os_tick` is 0 in every cycle that follows a cycle in which `enable` was low.
- R9: With `hs_sel` low, `baud_tick` pulses one clock after every 16th `os_tick` pulse, counted from the start of the run.
- R10: With `hs_sel` high, `baud_tick` pulses one clock after every 8th `os_tick` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Module enable; ticks are suppressed while low |
| hs_sel | input | 1 | Fast oversampling: 8 ticks per baud period instead of 16 |
| div_int_wr | input | 1 | Strobe that stages the integer divisor |
| div_int_wdata | input | 16 | Integer divisor value to stage |
| div_frac_wr | input | 1 | Strobe that stages the fractional divisor |
| div_frac_wdata | input | 6 | Fractional divisor value to stage, in 1/64 steps |
| lcr_wr | input | 1 | Line-control write strobe; commits the staged divisor |
| tx_busy | input | 1 | Transmit engine is in the middle of a character |
| rx_busy | input | 1 | Receive engine is in the middle of a character |
| os_tick | output | 1 | Oversampling enable tick |
| baud_tick | output | 1 | Baud-period (1x) indicator |

## Verification
Some properties are checked on every cycle. Ticks are silent after a disabled cycle. A stretched period only ever follows a counting state, and never occurs at unity ratio. A tick lasts one clock when the ratio is at least 2. The active divisor changes only from the armed state, and never while an engine is busy. Each baud pulse trails an oversampling tick. The exact period sequence the accumulator produces for a given fraction cannot be seen by a single-cycle property. Neither can the 16-tick and 8-tick baud spacing, nor the rule that a commit waits out a busy window before the old ratio is replaced. These are shown by scoreboard scenarios that predict each tick interval from the arithmetic in the requirements.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

    // Tick timer states
    typedef enum logic [1:0] {
        TG_OFF = 2'd0,
        TG_RUN = 2'd1,
        TG_PAD = 2'd2
    } tg_state_e;

    // Divisor commit states
    typedef enum logic {
        CM_SYNCED = 1'b0,
        CM_ARMED  = 1'b1
    } cm_state_e;

endpackage

// File: rtl/baud_div_stage.sv
module baud_div_stage
    import baud_gen_pkg::*;
#(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              int_wr,
    input  logic [INT_W-1:0]  int_wdata,
    input  logic              frac_wr,
    input  logic [FRAC_W-1:0] frac_wdata,
    input  logic              lcr_wr,
    input  logic              tx_busy,
    input  logic              rx_busy,
    output logic [INT_W-1:0]  act_int,
    output logic [FRAC_W-1:0] act_frac,
    output logic              load
);

    cm_state_e         st_q, st_d;
    logic [INT_W-1:0]  stage_int_q, pend_int_q;
    logic [FRAC_W-1:0] stage_frac_q, pend_frac_q;
    logic              engines_idle;
    logic              do_apply;

    assign engines_idle = !tx_busy && !rx_busy;
    assign do_apply     = (st_q == CM_ARMED) && !lcr_wr && engines_idle;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CM_SYNCED;
        else        st_q <= st_d;
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CM_SYNCED: if (lcr_wr) st_d = CM_ARMED;
            CM_ARMED: begin
                if (lcr_wr)             st_d = CM_ARMED;
                else if (engines_idle)  st_d = CM_SYNCED;
            end
            default: st_d = CM_SYNCED;
        endcase
    end

    // Staging, pending and active divisor registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_int_q  <= '0;
            stage_frac_q <= '0;
            pend_int_q   <= '0;
            pend_frac_q  <= '0;
            act_int      <= '0;
            act_frac     <= '0;
            load         <= 1'b0;
        end else begin
            load <= 1'b0;
            if (int_wr)  stage_int_q  <= int_wdata;
            if (frac_wr) stage_frac_q <= frac_wdata;
            if (lcr_wr) begin
                pend_int_q  <= stage_int_q;
                pend_frac_q <= stage_frac_q;
            end
            if (do_apply) begin
                act_int  <= pend_int_q;
                act_frac <= pend_frac_q;
                load     <= 1'b1;
            end
        end
    end

    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy || rx_busy) |=> ($stable(act_int) && $stable(act_frac))); // R7

    AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> $past(!tx_busy && !rx_busy)); // R7

    AST_CHANGE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(act_int) && $stable(act_frac)) |-> $past(st_q == CM_ARMED)); // R6

endmodule

// File: rtl/baud_frac_timer.sv
module baud_frac_timer
    import baud_gen_pkg::*;
#(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              load,
    input  logic [INT_W-1:0]  act_int,
    input  logic [FRAC_W-1:0] act_frac,
    output logic              os_tick
);

    localparam int SUM_W = FRAC_W + 1;

    tg_state_e         st_q, st_d;
    logic [INT_W-1:0]  cnt_q;
    logic [FRAC_W-1:0] acc_q;
    logic [INT_W-1:0]  last_cnt;
    logic [FRAC_W-1:0] frac_eff;
    logic [SUM_W-1:0]  sum;
    logic              stretch;
    logic              at_end;

    // Integer 0 means ratio 1 and ignores the fraction
    assign last_cnt = (act_int == '0) ? '0 : act_int - INT_W'(1);
    assign frac_eff = (act_int == '0) ? '0 : act_frac;
    assign sum      = {1'b0, acc_q} + {1'b0, frac_eff};
    assign stretch  = sum[FRAC_W];
    assign at_end   = (cnt_q == last_cnt);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TG_OFF;
        else        st_q <= st_d;
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d = TG_OFF;
        end else if (load) begin
            st_d = TG_RUN;
        end else begin
            unique case (st_q)
                TG_OFF: st_d = TG_RUN;
                TG_RUN: st_d = (at_end && stretch) ? TG_PAD : TG_RUN;
                TG_PAD: st_d = TG_RUN;
                default: st_d = TG_OFF;
            endcase
        end
    end

    // Counter, accumulator and tick output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            acc_q   <= '0;
            os_tick <= 1'b0;
        end else begin
            os_tick <= 1'b0;
            if (load || !enable) begin
                cnt_q <= '0;
                acc_q <= '0;
            end else begin
                unique case (st_q)
                    TG_OFF: begin
                        cnt_q <= '0;
                        acc_q <= '0;
                    end
                    TG_RUN: begin
                        if (at_end) begin
                            cnt_q <= '0;
                            if (!stretch) begin
                                os_tick <= 1'b1;
                                acc_q   <= sum[FRAC_W-1:0];
                            end
                        end else begin
                            cnt_q <= cnt_q + INT_W'(1);
                        end
                    end
                    TG_PAD: begin
                        cnt_q   <= '0;
                        os_tick <= 1'b1;
                        acc_q   <= sum[FRAC_W-1:0];
                    end
                    default: cnt_q <= '0;
                endcase
            end
        end
    end

    AST_QUIET_AFTER_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable) |-> !os_tick); // R8

    AST_PAD_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TG_PAD) |-> ($past(st_q) == TG_RUN)); // R3

    AST_NO_PAD_AT_UNITY: assert property (@(posedge clk) disable iff (!rst_n)
        (act_int == '0) |-> (st_q != TG_PAD)); // R4

    AST_TICK_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (os_tick && act_int > INT_W'(1)) |=> !os_tick); // R2

endmodule

// File: rtl/baud_os_divider.sv
module baud_os_divider #(
    parameter int OS_STD  = 16,
    parameter int OS_FAST = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic hs_sel,
    input  logic os_tick,
    output logic baud_tick
);

    localparam int CNT_W = $clog2(OS_STD);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_cnt;

    assign last_cnt = hs_sel ? CNT_W'(OS_FAST - 1) : CNT_W'(OS_STD - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            baud_tick <= 1'b0;
        end else begin
            baud_tick <= 1'b0;
            if (restart) begin
                cnt_q <= '0;
            end else if (os_tick) begin
                if (cnt_q >= last_cnt) begin
                    cnt_q     <= '0;
                    baud_tick <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end
        end
    end

    AST_BAUD_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> $past(os_tick)); // R9

endmodule

// File: rtl/baud_rate_gen.sv
module baud_rate_gen #(
    parameter int INT_W   = 16,
    parameter int FRAC_W  = 6,
    parameter int OS_STD  = 16,
    parameter int OS_FAST = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              hs_sel,
    input  logic              div_int_wr,
    input  logic [INT_W-1:0]  div_int_wdata,
    input  logic              div_frac_wr,
    input  logic [FRAC_W-1:0] div_frac_wdata,
    input  logic              lcr_wr,
    input  logic              tx_busy,
    input  logic              rx_busy,
    output logic              os_tick,
    output logic              baud_tick
);

    logic [INT_W-1:0]  act_int;
    logic [FRAC_W-1:0] act_frac;
    logic              load;
    logic              os_restart;

    assign os_restart = load || !enable;

    baud_div_stage #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .int_wr     (div_int_wr),
        .int_wdata  (div_int_wdata),
        .frac_wr    (div_frac_wr),
        .frac_wdata (div_frac_wdata),
        .lcr_wr     (lcr_wr),
        .tx_busy    (tx_busy),
        .rx_busy    (rx_busy),
        .act_int    (act_int),
        .act_frac   (act_frac),
        .load       (load)
    );

    baud_frac_timer #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .load     (load),
        .act_int  (act_int),
        .act_frac (act_frac),
        .os_tick  (os_tick)
    );

    baud_os_divider #(.OS_STD(OS_STD), .OS_FAST(OS_FAST)) u_osdiv (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (os_restart),
        .hs_sel    (hs_sel),
        .os_tick   (os_tick),
        .baud_tick (baud_tick)
    );

endmodule

// File: tb/baud_rate_gen_bench.sv
module baud_rate_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        hs_sel = 1'b0;
    logic        div_int_wr = 1'b0;
    logic [15:0] div_int_wdata = '0;
    logic        div_frac_wr = 1'b0;
    logic [5:0]  div_frac_wdata = '0;
    logic        lcr_wr = 1'b0;
    logic        tx_busy = 1'b0;
    logic        rx_busy = 1'b0;
    logic        os_tick;
    logic        baud_tick;

    int    nchecks = 0;
    int    nerrors = 0;
    bit    finished = 0;
    int    cyc = 0;
    int    exp_q[$];
    string cur_req = "R1";
    bit    scoring = 0;
    bit    have_ref = 0;
    int    ref_cyc = 0;
    bit    bscore = 0;
    bit    bref = 0;
    int    bcnt = 0;
    int    bexp = 16;
    int    bdone = 0;

    always #4 clk = ~clk;

    baud_rate_gen u_baud_rate_gen (
        .clk            (clk),
        .rst_n          (rst_n),
        .enable         (enable),
        .hs_sel         (hs_sel),
        .div_int_wr     (div_int_wr),
        .div_int_wdata  (div_int_wdata),
        .div_frac_wr    (div_frac_wr),
        .div_frac_wdata (div_frac_wdata),
        .lcr_wr         (lcr_wr),
        .tx_busy        (tx_busy),
        .rx_busy        (rx_busy),
        .os_tick        (os_tick),
        .baud_tick      (baud_tick)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchecks++;
        if (!ok) begin
            nerrors++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
            $finish;
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    // Tick-interval monitor: pops one expected interval per tick
    always @(negedge clk) begin
        cyc++;
        if (!scoring) begin
            have_ref = 0;
        end else if (os_tick) begin
            if (have_ref && exp_q.size() > 0) begin
                int e;
                e = exp_q.pop_front();
                chk((cyc - ref_cyc) == e, cur_req, cyc - ref_cyc, e);
            end
            have_ref = 1;
            ref_cyc = cyc;
        end
    end

    // Baud monitor: counts oversampling ticks between baud pulses
    always @(negedge clk) begin
        if (!bscore) begin
            bref = 0;
            bcnt = 0;
        end else begin
            if (baud_tick) begin
                if (bref) begin
                    chk(bcnt == bexp, (bexp == 16) ? "R9" : "R10", bcnt, bexp);
                    bdone++;
                end
                bref = 1;
                bcnt = 0;
            end
            if (os_tick) bcnt++;
        end
    end

    // Driver: predict intervals from the requirement arithmetic
    task automatic push_pattern(input int k, input int f, input int n);
        int acc = 0;
        for (int i = 0; i <= n; i++) begin
            int s;
            int len;
            s = acc + ((k == 0) ? 0 : f);
            len = (k == 0) ? 1 : (k + ((s >= 64) ? 1 : 0));
            acc = s % 64;
            if (i > 0) exp_q.push_back(len);
        end
    endtask

    task automatic run_scored(input string req, input int k, input int f, input int n);
        enable = 1'b0;
        step(3);
        cur_req = req;
        exp_q.delete();
        push_pattern(k, f, n);
        scoring = 1;
        enable = 1'b1;
        for (int i = 0; i < 4000 && exp_q.size() > 0; i++) step(1);
        chk(exp_q.size() == 0, req, exp_q.size(), 0);
        scoring = 0;
        step(1);
    endtask

    task automatic stage_div(input int k, input int f, input bit commit);
        div_int_wr = 1'b1;  div_int_wdata = 16'(k);
        div_frac_wr = 1'b1; div_frac_wdata = 6'(f);
        step(1);
        div_int_wr = 1'b0;  div_frac_wr = 1'b0;
        if (commit) begin
            lcr_wr = 1'b1;
            step(1);
            lcr_wr = 1'b0;
        end
        step(4);
    endtask

    task automatic baud_run(input bit hs, input int k);
        enable = 1'b0;
        stage_div(k, 0, 1);
        hs_sel = hs;
        bexp = hs ? 8 : 16;
        bdone = 0;
        bscore = 1;
        enable = 1'b1;
        for (int i = 0; i < 3000 && bdone < 3; i++) step(1);
        chk(bdone >= 3, hs ? "R10" : "R9", bdone, 3);
        bscore = 0;
        step(1);
    endtask

    initial begin
        #(8 * 150000);
        nerrors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: outputs quiet during reset even with enable high
        enable = 1'b1;
        step(3);
        @(negedge clk);
        chk(os_tick == 1'b0, "R1", os_tick, 0);
        chk(baud_tick == 1'b0, "R1", baud_tick, 0);
        step(2);
        rst_n = 1'b1;
        step(2);

        // R1: reset divisor gives a tick on every clock
        run_scored("R1", 0, 0, 20);

        // R5: staging without line-control write changes nothing
        stage_div(5, 17, 0);
        run_scored("R5", 0, 0, 10);

        // R6 / R2: commit integer 5, fraction 0
        stage_div(5, 0, 1);
        run_scored("R2", 5, 0, 10);

        // R3: fractional dithering, two patterns
        stage_div(3, 32, 1);
        run_scored("R3", 3, 32, 12);
        stage_div(2, 21, 1);
        run_scored("R3", 2, 21, 16);

        // R4: integer 0 ignores the fraction
        stage_div(0, 40, 1);
        run_scored("R4", 0, 40, 10);

        // R7: commit while engines are busy is held back
        tx_busy = 1'b1;
        stage_div(7, 0, 1);
        run_scored("R7", 0, 0, 10);
        tx_busy = 1'b0;
        rx_busy = 1'b1;
        step(3);
        run_scored("R7", 0, 0, 10);
        rx_busy = 1'b0;
        step(3);
        run_scored("R7", 7, 0, 6);

        // R8: no ticks while disabled
        begin
            int seen = 0;
            enable = 1'b0;
            step(2);
            for (int i = 0; i < 30; i++) begin
                @(negedge clk);
                if (os_tick) seen++;
            end
            chk(seen == 0, "R8", seen, 0);
        end

        // R9 / R10: baud indicator spacing
        baud_run(1'b0, 2);
        baud_run(1'b1, 2);
        baud_run(1'b1, 0);

        finish_run();
    end

endmodule